// File: doc/BRIEF.md
# Peripheral protection permission resolver

This block sits between a security register file and a set of peripheral protection controllers. It keeps three permission words for each controller: one marking which ports are non-secure, one giving the privilege setting used for secure ports, and one giving the privilege setting used for non-secure ports. From these it drives, for every port, a non-secure flag and an access-permission flag. The permission flag takes the non-secure privilege bit when the port is marked non-secure, and the secure privilege bit when it is not. There are ten controllers: two internal APB controllers, a group of APB expansion controllers and a group of AHB expansion controllers.

The block also handles the interrupt side of those controllers. It samples each controller's interrupt level into one shared 32-bit status word, at fixed and non-contiguous bit positions. It drives each controller's interrupt-enable line from a stored enable word, and pulses each controller's interrupt-clear line when software writes the clear register. It also holds a single response-configuration bit. Address decoding stays in the register file, which hands over write strobes, a controller index, a word selector and the write data.

Every controller owns a 16-bit slot in the flat port vectors: controller c, port p sits at bit c*16+p. Controller indices are 0 and 1 for the internal APB controllers, 2 to 5 for APB expansion controllers 0 to 3, and 6 to 9 for AHB expansion controllers 0 to 3.

Top module: `ppc_perm_resolver`

## Requirements
- R1: For every port, port_ap equals the stored non-secure-privilege bit when that port's stored non-secure bit is 1, and the stored secure-privilege bit otherwise. The output is combinational from the stored words.
- R2: A permission write stores wr_data masked to the controller's port count. Controller 0 has 13 ports, controller 1 has 1 port and every expansion controller has 16 ports. Bits at or above the port count read back as 0 on the port outputs.
- R3: port_nonsec bit c*16+p equals the stored non-secure bit p of controller c. A write is visible from the clock edge that takes it.
- R4: irq_status_word bit positions are fixed: internal APB controllers 0 and 1 use bits 0 and 1, APB expansion controller i uses bit 4+i, and AHB expansion controller i uses bit 20+i. All other bits are 0.
- R5: Each status bit equals the level of its controller's ctl_irq_status input one clock earlier. It sets and clears with that input.
- R6: ctl_irq_enable[c] equals bit R4-position(c) of the word most recently written with inten_wr_en.
- R7: resp_cfg equals bit 0 of the word most recently written with respcfg_wr_en.
- R8: A cycle with intclr_wr_en drives ctl_irq_clear[c] high for exactly the next cycle when wr_data has a 1 at controller c's R4 position. In a cycle after one without intclr_wr_en, every clear line is 0.
- R9: After reset, port_nonsec, port_ap, ctl_irq_enable, ctl_irq_clear, irq_status_word and resp_cfg are all 0.
- R10: perm_wr_sel encodes 0 = non-secure word, 1 = secure-privilege word, 2 = non-secure-privilege word, 3 = no write. A permission write with selector 3, or with perm_wr_idx of 10 or more, changes no port output. A write to one controller leaves all others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perm_wr_en | input | 1 | Permission word write strobe |
| perm_wr_sel | input | 2 | Word selector (0 non-secure, 1 secure priv, 2 non-secure priv, 3 none) |
| perm_wr_idx | input | 4 | Target controller index |
| wr_data | input | 32 | Write data shared by all strobes |
| inten_wr_en | input | 1 | Interrupt-enable word write strobe |
| intclr_wr_en | input | 1 | Interrupt-clear word write strobe |
| respcfg_wr_en | input | 1 | Response-configuration write strobe |
| ctl_irq_status | input | 10 | Interrupt level from each controller |
| port_nonsec | output | 160 | Per-port non-secure flags, 16 slots per controller |
| port_ap | output | 160 | Per-port access-permission flags |
| ctl_irq_enable | output | 10 | Interrupt enable per controller |
| ctl_irq_clear | output | 10 | One-cycle interrupt clear per controller |
| irq_status_word | output | 32 | Packed interrupt status |
| resp_cfg | output | 1 | Response configuration |

## Verification
The mux is tried with all-set and all-clear non-secure words and with alternating non-secure, secure and non-secure-privilege patterns. These patterns tell a correct per-port select apart from a swapped select or one driven by the wrong word. Writes of all ones to controllers with 1, 13 and 16 ports separate correct masking from a mask that is off by one or missing. One-hot interrupt levels on each controller pin down every status and enable position. Back-to-back and isolated clear writes show whether the pulse lasts exactly one cycle. A long stretch of random writes, including reserved selectors and out-of-range indices, is then compared every clock against a behavioural model.

// File: rtl/ppc_res_pkg.sv
package ppc_res_pkg;

  localparam int MAX_PORTS = 16;

  typedef enum logic [1:0] {
    PW_NONSEC = 2'd0,
    PW_SPRIV  = 2'd1,
    PW_NSPRIV = 2'd2,
    PW_NONE   = 2'd3
  } perm_sel_e;

  // number of ports served by controller c
  function automatic int ctl_port_count(input int c, input int p0, input int p1,
                                        input int pexp);
    if (c == 0) return p0;
    if (c == 1) return p1;
    return pexp;
  endfunction

  // status / enable / clear bit position of controller c
  function automatic int ctl_irq_pos(input int c, input int n_apbx,
                                     input int apbx_base, input int ahbx_base);
    if (c < 2) return c;
    if (c < 2 + n_apbx) return apbx_base + (c - 2);
    return ahbx_base + (c - 2 - n_apbx);
  endfunction

  function automatic logic [MAX_PORTS-1:0] port_mask(input int n);
    logic [MAX_PORTS-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_PORTS; i++)
      if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  // per-port privilege select
  function automatic logic [MAX_PORTS-1:0] resolve_ap(input logic [MAX_PORTS-1:0] ns,
                                                      input logic [MAX_PORTS-1:0] sp,
                                                      input logic [MAX_PORTS-1:0] nsp);
    return (ns & nsp) | (~ns & sp);
  endfunction

endpackage

// File: rtl/ppc_ctl_slice.sv
module ppc_ctl_slice
  import ppc_res_pkg::*;
#(
  parameter int NPORTS = 16,
  parameter int IDX    = 0,
  parameter int IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [MAX_PORTS-1:0] wr_data,
  output logic [MAX_PORTS-1:0] nonsec,
  output logic [MAX_PORTS-1:0] ap
);

  localparam logic [MAX_PORTS-1:0] MASK = port_mask(NPORTS);

  logic [MAX_PORTS-1:0] ns_q, sp_q, nsp_q;
  perm_sel_e            sel;
  logic                 hit;

  assign sel = perm_sel_e'(wr_sel);
  assign hit = wr_en && (wr_idx == IDX_W'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else if (hit) begin
      case (sel)
        PW_NONSEC: ns_q  <= wr_data & MASK;
        PW_SPRIV:  sp_q  <= wr_data & MASK;
        PW_NSPRIV: nsp_q <= wr_data & MASK;
        default:   ;
      endcase
    end
  end

  assign nonsec = ns_q;
  assign ap     = resolve_ap(ns_q, sp_q, nsp_q);

  // R2, R3: non-secure write lands masked on the port flags
  p_ns_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == PW_NONSEC) |=> (nonsec == ($past(wr_data) & MASK)));

  // R1: all ports non-secure, so the permission follows the non-secure privilege word
  p_ap_nsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == PW_NSPRIV && nonsec == MASK) |=> (ap == ($past(wr_data) & MASK)));

  // R1: all ports secure, so the permission follows the secure privilege word
  p_ap_sp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == PW_SPRIV && nonsec == '0) |=> (ap == ($past(wr_data) & MASK)));

  // R10: no write to this slice leaves its outputs alone
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && sel != PW_NONE) |=> ($stable(nonsec) && $stable(ap)));

endmodule

// File: rtl/ppc_irq_hub.sv
module ppc_irq_hub
  import ppc_res_pkg::*;
#(
  parameter int NCTL      = 10,
  parameter int N_APBX    = 4,
  parameter int APBX_BASE = 4,
  parameter int AHBX_BASE = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inten_wr,
  input  logic            intclr_wr,
  input  logic [31:0]     wr_data,
  input  logic [NCTL-1:0] irq_in,
  output logic [NCTL-1:0] irq_en,
  output logic [NCTL-1:0] irq_clr,
  output logic [31:0]     status_word
);

  logic [NCTL-1:0] stat_vec;

  for (genvar c = 0; c < NCTL; c++) begin : g_ctl
    localparam int POS = ctl_irq_pos(c, N_APBX, APBX_BASE, AHBX_BASE);
    logic en_b, clr_b, st_b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_b  <= 1'b0;
        clr_b <= 1'b0;
        st_b  <= 1'b0;
      end else begin
        st_b  <= irq_in[c];
        clr_b <= intclr_wr & wr_data[POS];
        if (inten_wr) en_b <= wr_data[POS];
      end
    end

    assign irq_en[c]   = en_b;
    assign irq_clr[c]  = clr_b;
    assign stat_vec[c] = st_b;

    // R5, R4: status bit at its fixed position tracks the level one clock late
    p_status_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_word[POS] == $past(irq_in[c])));

    // R6: enable line picks the written bit at its position
    p_enable_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inten_wr |=> (irq_en[c] == $past(wr_data[POS])));

    // R8: clear line pulses on a written 1 at its position
    p_clear_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      intclr_wr |=> (irq_clr[c] == $past(wr_data[POS])));
  end

  always_comb begin
    status_word = '0;
    for (int c = 0; c < NCTL; c++)
      status_word[ctl_irq_pos(c, N_APBX, APBX_BASE, AHBX_BASE)] = stat_vec[c];
  end

  // R8: without a clear write no clear line is high in the following cycle
  p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !intclr_wr |=> (irq_clr == '0));

endmodule

// File: rtl/ppc_resp_cfg.sv
module ppc_resp_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= 1'b0;
    else if (wr_en) cfg <= wr_bit;
  end

  // R7: written value appears and then holds
  p_resp_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg == $past(wr_bit)));
  p_resp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

endmodule

// File: rtl/ppc_perm_resolver.sv
module ppc_perm_resolver
  import ppc_res_pkg::*;
#(
  parameter int INT0_PORTS = 13,
  parameter int INT1_PORTS = 1,
  parameter int EXP_PORTS  = 16,
  parameter int N_APBX     = 4,
  parameter int N_AHBX     = 4,
  parameter int APBX_BASE  = 4,
  parameter int AHBX_BASE  = 20,
  parameter int IDX_W      = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     perm_wr_en,
  input  logic [1:0]                               perm_wr_sel,
  input  logic [IDX_W-1:0]                         perm_wr_idx,
  input  logic [31:0]                              wr_data,
  input  logic                                     inten_wr_en,
  input  logic                                     intclr_wr_en,
  input  logic                                     respcfg_wr_en,
  input  logic [2+N_APBX+N_AHBX-1:0]               ctl_irq_status,
  output logic [(2+N_APBX+N_AHBX)*MAX_PORTS-1:0]   port_nonsec,
  output logic [(2+N_APBX+N_AHBX)*MAX_PORTS-1:0]   port_ap,
  output logic [2+N_APBX+N_AHBX-1:0]               ctl_irq_enable,
  output logic [2+N_APBX+N_AHBX-1:0]               ctl_irq_clear,
  output logic [31:0]                              irq_status_word,
  output logic                                     resp_cfg
);

  localparam int NCTL = 2 + N_APBX + N_AHBX;

  for (genvar c = 0; c < NCTL; c++) begin : g_slice
    localparam int NP = ctl_port_count(c, INT0_PORTS, INT1_PORTS, EXP_PORTS);

    ppc_ctl_slice #(
      .NPORTS (NP),
      .IDX    (c),
      .IDX_W  (IDX_W)
    ) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (perm_wr_en),
      .wr_sel  (perm_wr_sel),
      .wr_idx  (perm_wr_idx),
      .wr_data (wr_data[MAX_PORTS-1:0]),
      .nonsec  (port_nonsec[c*MAX_PORTS +: MAX_PORTS]),
      .ap      (port_ap[c*MAX_PORTS +: MAX_PORTS])
    );
  end

  ppc_irq_hub #(
    .NCTL      (NCTL),
    .N_APBX    (N_APBX),
    .APBX_BASE (APBX_BASE),
    .AHBX_BASE (AHBX_BASE)
  ) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .inten_wr    (inten_wr_en),
    .intclr_wr   (intclr_wr_en),
    .wr_data     (wr_data),
    .irq_in      (ctl_irq_status),
    .irq_en      (ctl_irq_enable),
    .irq_clr     (ctl_irq_clear),
    .status_word (irq_status_word)
  );

  ppc_resp_cfg u_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (respcfg_wr_en),
    .wr_bit (wr_data[0]),
    .cfg    (resp_cfg)
  );

endmodule

// File: tb/ppc_perm_resolver_bench.sv
`timescale 1ns/1ps
module ppc_perm_resolver_bench;

  localparam int NC = 10;
  localparam int W  = NC * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          perm_wr_en = 1'b0;
  logic [1:0]    perm_wr_sel = 2'd0;
  logic [3:0]    perm_wr_idx = 4'd0;
  logic [31:0]   wr_data = '0;
  logic          inten_wr_en = 1'b0, intclr_wr_en = 1'b0, respcfg_wr_en = 1'b0;
  logic [NC-1:0] ctl_irq_status = '0;
  logic [W-1:0]  port_nonsec, port_ap;
  logic [NC-1:0] ctl_irq_enable, ctl_irq_clear;
  logic [31:0]   irq_status_word;
  logic          resp_cfg;

  always #2.5 clk = ~clk;

  ppc_perm_resolver u_ppc_perm_resolver (
    .clk(clk), .rst_n(rst_n), .perm_wr_en(perm_wr_en), .perm_wr_sel(perm_wr_sel),
    .perm_wr_idx(perm_wr_idx), .wr_data(wr_data), .inten_wr_en(inten_wr_en),
    .intclr_wr_en(intclr_wr_en), .respcfg_wr_en(respcfg_wr_en),
    .ctl_irq_status(ctl_irq_status), .port_nonsec(port_nonsec), .port_ap(port_ap),
    .ctl_irq_enable(ctl_irq_enable), .ctl_irq_clear(ctl_irq_clear),
    .irq_status_word(irq_status_word), .resp_cfg(resp_cfg)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  int unsigned m_ns[NC], m_sp[NC], m_nsp[NC];
  bit          m_en[NC], m_clr[NC], m_st[NC];
  bit          m_resp;
  int unsigned inten_word;

  function automatic int nports(int c);
    case (c)
      0: return 13;
      1: return 1;
      default: return 16;
    endcase
  endfunction

  function automatic int bitpos(int c);
    case (c)
      0: return 0;   1: return 1;
      2: return 4;   3: return 5;   4: return 6;   5: return 7;
      6: return 20;  7: return 21;  8: return 22;  default: return 23;
    endcase
  endfunction

  function automatic int unsigned lowmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_ns[c] = 0; m_sp[c] = 0; m_nsp[c] = 0;
        m_en[c] = 0; m_clr[c] = 0; m_st[c] = 0;
      end
      m_resp = 0;
      inten_word = 0;
    end else begin
      if (perm_wr_en && perm_wr_idx < NC) begin
        if (perm_wr_sel == 2'd0) m_ns[perm_wr_idx]  = wr_data & lowmask(nports(perm_wr_idx));
        if (perm_wr_sel == 2'd1) m_sp[perm_wr_idx]  = wr_data & lowmask(nports(perm_wr_idx));
        if (perm_wr_sel == 2'd2) m_nsp[perm_wr_idx] = wr_data & lowmask(nports(perm_wr_idx));
      end
      if (inten_wr_en) inten_word = wr_data;
      if (respcfg_wr_en) m_resp = wr_data[0];
      for (int c = 0; c < NC; c++) begin
        m_clr[c] = intclr_wr_en && wr_data[bitpos(c)];
        m_en[c]  = inten_word[bitpos(c)];
        m_st[c]  = ctl_irq_status[c];
      end
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0]  e_ns, e_ap;
    logic [NC-1:0] e_en, e_clr;
    logic [31:0]   e_st;
    e_ns = '0; e_ap = '0; e_en = '0; e_clr = '0; e_st = '0;
    for (int c = 0; c < NC; c++) begin
      for (int p = 0; p < 16; p++) begin
        e_ns[c*16+p] = m_ns[c][p];
        e_ap[c*16+p] = m_ns[c][p] ? m_nsp[c][p] : m_sp[c][p];
      end
      e_en[c]         = m_en[c];
      e_clr[c]        = m_clr[c];
      e_st[bitpos(c)] = m_st[c];
    end
    chk("R3 port_nonsec", port_nonsec, e_ns);
    chk("R1 port_ap", port_ap, e_ap);
    chk("R4/R5 irq_status_word", W'(irq_status_word), W'(e_st));
    chk("R6 ctl_irq_enable", W'(ctl_irq_enable), W'(e_en));
    chk("R8 ctl_irq_clear", W'(ctl_irq_clear), W'(e_clr));
    chk("R7 resp_cfg", W'(resp_cfg), W'(m_resp));
  endtask

  // one cycle: compare after the previous edge, then drop all strobes
  task automatic tick();
    @(negedge clk);
    compare_all();
    perm_wr_en = 0; inten_wr_en = 0; intclr_wr_en = 0; respcfg_wr_en = 0;
  endtask

  task automatic perm_wr(int idx, int sel, logic [31:0] d);
    perm_wr_en = 1; perm_wr_idx = 4'(idx); perm_wr_sel = 2'(sel); wr_data = d;
  endtask

  initial begin
    logic [W-1:0] snap_ns, snap_ap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R9: reset state at the ports
    chk("R9 reset nonsec", port_nonsec, '0);
    chk("R9 reset ap", port_ap, '0);
    chk("R9 reset status/enable/clear/resp",
        W'({irq_status_word, ctl_irq_enable, ctl_irq_clear, resp_cfg}), '0);

    // R2: all-ones to 1-port, 13-port and 16-port controllers
    perm_wr(1, 0, 32'hFFFF_FFFF); tick();
    perm_wr(0, 0, 32'hFFFF_FFFF); tick();
    perm_wr(7, 0, 32'hFFFF_FFFF); tick();
    chk("R2 mask 1-port", W'(port_nonsec[16 +: 16]), W'(16'h0001));
    chk("R2 mask 13-port", W'(port_nonsec[0 +: 16]), W'(16'h1FFF));
    chk("R2 mask 16-port", W'(port_nonsec[7*16 +: 16]), W'(16'hFFFF));

    // R1: controller 7 all non-secure, privilege words differ
    perm_wr(7, 1, 32'h0000_00F0); tick();
    perm_wr(7, 2, 32'h0000_A5A5); tick();
    chk("R1 ap from nsp", W'(port_ap[7*16 +: 16]), W'(16'hA5A5));
    perm_wr(7, 0, 32'h0000_FF00); tick();
    tick();
    chk("R1 ap mixed", W'(port_ap[7*16 +: 16]), W'(16'hA5F0));

    // R10: reserved selector and out-of-range indices do nothing
    snap_ns = port_nonsec; snap_ap = port_ap;
    perm_wr(7, 3, 32'h0000_0000); tick();
    perm_wr(12, 0, 32'h0000_0000); tick();
    perm_wr(15, 2, 32'hFFFF_FFFF); tick();
    tick();
    chk("R10 nonsec unchanged", port_nonsec, snap_ns);
    chk("R10 ap unchanged", port_ap, snap_ap);

    // R4: one-hot levels per controller
    for (int c = 0; c < NC; c++) begin
      ctl_irq_status = NC'(1) << c;
      tick();
      tick();
      chk("R4 status position", W'(irq_status_word), W'(32'd1 << bitpos(c)));
    end
    ctl_irq_status = '0;

    // R6: enable word with every bit set
    wr_data = 32'hFFFF_FFFF; inten_wr_en = 1; tick();
    chk("R6 enable all", W'(ctl_irq_enable), W'({NC{1'b1}}));

    // R8: clear of APB expansion controller 1 (bit 5) lasts one cycle
    wr_data = 32'h0000_0020; intclr_wr_en = 1; tick();
    chk("R8 clear pulse", W'(ctl_irq_clear), W'(10'b00_0000_1000));
    tick();
    chk("R8 clear ends", W'(ctl_irq_clear), '0);
    wr_data = 32'h00F0_00F3; intclr_wr_en = 1; tick();
    wr_data = 32'h00F0_00F3; intclr_wr_en = 1; tick();
    chk("R8 back-to-back clear", W'(ctl_irq_clear), W'({NC{1'b1}}));

    // R7: response configuration
    wr_data = 32'h0000_0001; respcfg_wr_en = 1; tick();
    chk("R7 resp set", W'(resp_cfg), W'(1'b1));

    // random phase, compared every clock against the model
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom;
      wr_data = $urandom;
      case (r % 8)
        0, 1, 2: perm_wr(int'($urandom % 16), int'($urandom % 4), wr_data);
        3: inten_wr_en = 1;
        4: intclr_wr_en = 1;
        5: respcfg_wr_en = 1;
        default: ;
      endcase
      if (r[8]) ctl_irq_status = NC'($urandom);
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule